// File: doc/BRIEF.md
# Paced Pattern Output Buffer

This block sits between an upstream writer, such as a DMA engine streaming a pattern out of memory, and a parallel output port. The writer pushes words into an internal first-in first-out store over a valid/ready handshake. When the store fills, ready drops and the writer stalls until space frees up.

A programmable divider sets the rate at which words leave the store. Each divider tick moves the oldest stored word onto the output port and pulses an update strobe. A tick that finds the store empty leaves the port at its previous value and latches a sticky underrun flag. The flag stays set until an explicit clear pulse.

The port width is a parameter and may be 8, 16 or 32 bits. The store depth is set by an address-width parameter and does not depend on the port width. A 16K-entry store uses an address width of 14. Everything runs on one clock with a synchronous active-high reset.

Top module: `pattern_pacer`

## Requirements
- R1: After reset, out_data is zero, out_update and underrun are low, and in_ready is high because the store is empty.
- R2: in_ready is high exactly when fewer than 2**ADDR_W words are stored. A word is accepted on a clock edge where in_valid and in_ready are both high.
- R3: While the store is full, in_ready is low and in_valid has no effect. No word is lost or duplicated, so the output sequence equals the sequence of accepted words.
- R4: While enable is high and the divider value is N, a tick occurs every N+1 clocks. The first tick comes N clocks after enable goes high. N=0 gives a tick on every clock.
- R5: A tick with at least one stored word puts the oldest stored word on out_data in the next cycle and pulses out_update high for that one cycle.
- R6: A tick with the store empty leaves out_data unchanged and out_update low, and sets underrun in the next cycle.
- R7: underrun stays set until a cycle with clr_underrun high clears it. If a clear arrives in the same cycle as a new empty tick, underrun stays set.
- R8: While enable is low there are no ticks: out_data holds, underrun is not set, and the divider restarts from zero when enable rises again.
- R9: The store holds exactly 2**ADDR_W words for each legal DATA_W of 8, 16 or 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the rate divider; low stops output and underrun detection |
| rate_div | input | DIV_W | Divider value N; one tick every N+1 clocks |
| clr_underrun | input | 1 | Clear pulse for the sticky underrun flag |
| in_valid | input | 1 | Writer offers a word |
| in_data | input | DATA_W | Offered word |
| in_ready | output | 1 | Store can accept a word |
| out_data | output | DATA_W | Registered output port |
| out_update | output | 1 | High for the cycle in which out_data shows a newly popped word |
| underrun | output | 1 | Sticky flag: a tick found the store empty |

## Verification
Two cases are hard to reach from the ports. One is a clear pulse that lands in the same cycle as an empty tick. The other is a writer that keeps in_valid high against a full store while the divider pops words out. The bench sets up the first by running the divider at N=0 with an empty store, so every cycle is an empty tick and any clear coincides with one. For the second, it fills the store while the block is disabled, then sweeps every divider value against several valid duty patterns, with enable dropped mid-run. A cycle-level model computed from the requirements predicts every output on every cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;

  // What the output side does on a given cycle.
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,  // no tick this cycle
    EV_POP    = 2'd1,  // tick with a word available
    EV_STARVE = 2'd2   // tick with the store empty
  } pp_event_e;

  function automatic pp_event_e classify(input logic tick, input logic empty);
    if (!tick)      return EV_IDLE;
    else if (empty) return EV_STARVE;
    else            return EV_POP;
  endfunction

endpackage

// File: rtl/pp_pacer.sv
module pp_pacer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // Compare with >= so that lowering rate_div mid-period cannot skip a wrap.
  assign tick = enable && (cnt_q >= rate_div);

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R4: a nonzero divider never gives back-to-back ticks
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && rate_div != '0) |=> (!tick || rate_div == '0));

  // R8: the counter is at zero after a disabled cycle
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt_q == '0));

endmodule

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LVL_FULL = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [ADDR_W:0]   level_q;

  assign full  = (level_q == LVL_FULL);
  assign empty = (level_q == '0);

  // Storage write port, no reset so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  // Synchronous read into the RAM output register; it holds when not read.
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  // R9: level never exceeds the configured depth
  a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_FULL);

  // R3: the write side never pushes into a full store
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);

  // R5: the read side never pops an empty store
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rd_en);

endmodule

// File: rtl/pp_status.sv
module pp_status
  import pp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pp_event_e ev,
  input  logic      clr,
  output logic      update,
  output logic      underrun
);

  always_ff @(posedge clk) begin
    if (rst) begin
      update   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      update <= (ev == EV_POP);
      if (ev == EV_STARVE) underrun <= 1'b1;  // set wins over clear
      else if (clr)        underrun <= 1'b0;
    end
  end

  // R6: an empty tick raises the flag next cycle
  a_r6_starve_sets: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_STARVE) |=> underrun);

  // R7: without a clear the flag stays
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (underrun && !clr) |=> underrun);

  // R5: the strobe follows only a pop
  a_r5_strobe_source: assert property (@(posedge clk) disable iff (rst)
    (ev != EV_POP) |=> !update);

endmodule

// File: rtl/pattern_pacer.sv
module pattern_pacer
  import pp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  rate_div,
  input  logic              clr_underrun,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_update,
  output logic              underrun
);

  logic      tick, full, empty, push, pop;
  pp_event_e ev;

  pp_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .rate_div (rate_div),
    .tick     (tick)
  );

  assign ev       = classify(tick, empty);
  assign in_ready = !full;
  assign push     = in_valid && in_ready;
  assign pop      = (ev == EV_POP);

  pp_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_data (out_data),
    .full    (full),
    .empty   (empty)
  );

  pp_status u_status (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .clr      (clr_underrun),
    .update   (out_update),
    .underrun (underrun)
  );

  // R6: the port holds its value across an empty tick
  a_r6_hold_on_empty: assert property (@(posedge clk) disable iff (rst)
    (tick && empty) |=> $stable(out_data));

  // R8: with enable low the port and a clear flag stay put
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!enable && !underrun) |=> (!underrun && $stable(out_data)));

endmodule

// File: tb/pattern_pacer_bench.sv
module pattern_pacer_bench;
  localparam int DW = 8, AW = 3, DEPTH = 8, NW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, enable = 1'b0, clr = 1'b0, in_valid = 1'b0;
  logic [NW-1:0] rate_div = '0;
  logic [DW-1:0] in_data;
  logic in_ready, out_update, underrun;
  logic [DW-1:0] out_data;

  pattern_pacer #(.DATA_W(DW), .ADDR_W(AW), .DIV_W(NW)) u_pattern_pacer (
    .clk(clk), .rst(rst), .enable(enable), .rate_div(rate_div),
    .clr_underrun(clr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_data(out_data), .out_update(out_update),
    .underrun(underrun)
  );

  int checks = 0, errors = 0;
  int m_cnt = 0, m_count = 0, m_head = 0;
  logic [DW-1:0] mq [DEPTH];
  logic [DW-1:0] m_out = '0, next_word = '0;
  logic m_upd = 1'b0, m_und = 1'b0;
  int accepted = 0, upd_seen = 0;
  bit done = 0;

  assign in_data = next_word;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock; inputs must already be set.
  task automatic cycle();
    logic tk, rdy, wr, rd;
    int tail;
    tk   = enable && (m_cnt >= int'(rate_div));
    rdy  = (m_count < DEPTH);
    chk("R2 in_ready", in_ready, rdy);
    wr   = in_valid && rdy;
    rd   = tk && (m_count > 0);
    tail = (m_head + m_count) % DEPTH;
    @(posedge clk); #1;
    if (wr) begin mq[tail] = next_word; next_word = next_word + 1'b1; accepted++; end
    if (rd) begin m_out = mq[m_head]; m_head = (m_head + 1) % DEPTH; end
    m_upd = rd;
    if (tk && m_count == 0) m_und = 1'b1;
    else if (clr)           m_und = 1'b0;
    m_count = m_count + int'(wr) - int'(rd);
    if (!enable || tk) m_cnt = 0; else m_cnt++;
    if (out_update) upd_seen++;
    chk("R5 out_data", out_data, m_out);
    chk("R5 out_update", out_update, m_upd);
    chk("R7 underrun", underrun, m_und);
  endtask

  task automatic run(input int n, input int vmode);
    for (int i = 0; i < n; i++) begin
      case (vmode)
        0: in_valid = 1'b0;
        1: in_valid = 1'b1;
        2: in_valid = (i % 2 == 0);
        default: in_valid = (i % 3 != 0);
      endcase
      cycle();
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 out_data", out_data, 0);
    chk("R1 out_update", out_update, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 in_ready", in_ready, 1);

    // Empty ticks at N=0: port holds zero, flag sets
    enable = 1'b1; rate_div = 0;
    run(4, 0);
    chk("R6 hold", out_data, 0);
    chk("R6 flag", underrun, 1);

    // Clear while disabled
    enable = 1'b0; clr = 1'b1; run(1, 0); clr = 1'b0;
    chk("R7 cleared", underrun, 0);

    // Fill while disabled, writer keeps pushing against full
    accepted = 0;
    run(12, 1);
    chk("R9 depth", accepted, DEPTH);
    in_valid = 1'b1;
    chk("R3 stalled", in_ready, 0);
    cycle();
    in_valid = 1'b0;
    chk("R3 no extra word", accepted, DEPTH);

    // Divider N=3: 4 pops in 16 clocks after enable rises
    enable = 1'b1; rate_div = 3; upd_seen = 0;
    run(16, 0);
    chk("R4 tick count", upd_seen, 4);
    run(20, 0);
    chk("R6 hold last", out_data, DEPTH - 1);
    chk("R6 underrun", underrun, 1);

    // Clear coinciding with empty tick
    rate_div = 0; clr = 1'b1; run(1, 0); clr = 1'b0;
    chk("R7 set wins", underrun, 1);

    // Disabled: no flag after clear
    enable = 1'b0; clr = 1'b1; run(1, 0); clr = 1'b0;
    run(10, 0);
    chk("R8 no underrun when idle", underrun, 0);
    chk("R8 port held", out_data, DEPTH - 1);

    // Sweep divider values and writer patterns, enable dropped mid-run
    for (int n = 0; n < 8; n++) begin
      for (int vm = 0; vm < 4; vm++) begin
        rate_div = NW'(n);
        enable = 1'b1; run(14, vm);
        enable = 1'b0; run(3, (vm + 1) % 4);
        enable = 1'b1; run(14, 1);
        clr = 1'b1; run(1, vm); clr = 1'b0;
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule